// File: doc/BRIEF.md
# Clock-Control Configuration Port (SMBus Block-Write Slave)

This block is a write-only SMBus slave that loads a small bank of clock-control registers. A host sends a START, the device address with the write bit, a command byte of 00h, a byte count and then the data bytes. The data bytes fill the registers starting at register 0 and moving upward. Each byte is shifted in most significant bit first. The block acknowledges each byte it accepts by pulling SDA low during the ninth clock. A STOP may come after any complete byte, and every byte completed up to that point stays applied.

The register contents leave the block as one flat vector that drives the output-gating logic. Two strap inputs are captured once after reset and appear as read-only bits in register 0. Register 6 is a fixed identification byte. Reserved bits and read-only bits never change when the host writes them. Both bus lines are synchronized and filtered for glitches before they are decoded. The block drives SDA only during acknowledge bits.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset the registers hold the following values. Register i occupies `cfg_bytes[8i+7:8i]`. Reg0 = 08h, with bit 2 = `mode_strap` and bit 1 = `freq_strap`. Reg1 = 47h, reg2 = 7Fh, reg3 = C7h, reg4 = 3Fh, reg5 = 00h, reg6 = 08h. The strap inputs are captured once after reset, and later changes to them do not reach bits 2:1 of reg0.
- R2: The address byte D2h (address 69h, write bit 0) is acknowledged. An acknowledge means `sda_pull` is high during the ninth SCL high phase. Any other address byte is not acknowledged, and the rest of that transfer writes nothing.
- R3: A command byte of 00h is acknowledged. Any other command byte is not acknowledged, and the rest of the transfer writes nothing.
- R4: A byte count from 1 to 32 is acknowledged. A count of 0, or a count above 32, is not acknowledged, and nothing is written.
- R5: Data byte k (counting from 0) is acknowledged and written to register k, MSB first.
- R6: A STOP after a complete data byte keeps all bytes completed before it. A byte cut off by a STOP before its eighth bit is not written.
- R7: A write changes only these bits: reg0 bits 7, 5 and 3; reg1 bits 6 and 2:0; reg2 bits 6:0; reg3 all bits; reg4 bits 5:0; reg5 bits 6:0. All other bits, and the whole of reg6, keep their values.
- R8: Data bytes beyond the byte count are not acknowledged and are not written. Bytes within the count that fall past reg6 are acknowledged and discarded.
- R9: `sda_pull` never rises during a data bit. It changes only while the filtered SCL is low.
- R10: An SCL pulse shorter than `FILT_CYC` clocks has no effect on the transfer.
- R11: A repeated START restarts the transfer at the address phase, and the register index goes back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_pull | output | 1 | High pulls SDA low (drives the open-drain pad) |
| mode_strap | input | 1 | Mode strap, mirrored in reg0 bit 2 |
| freq_strap | input | 1 | Frequency strap, mirrored in reg0 bit 1 |
| cfg_bytes | output | 56 | Register bank, register i in bits [8i+7:8i] |

## Verification
The assertions assume a well-behaved host. The host never issues a STOP or a START while the slave holds SDA low for an acknowledge. It changes SDA only while SCL is low, except when it forms a START or a STOP. Each bus level is held for far longer than the filter window.

The bench master keeps to these rules. It holds every SCL phase for 16 clocks and moves SDA a full phase before each SCL edge. The only short pulse it injects is the deliberate SCL glitch, and that glitch falls inside an SCL low phase. Random transfers vary the address, the command, the count and the length, so they cover both acknowledged and refused transfers.

// File: rtl/cfgsm_pkg.sv
package cfgsm_pkg;

  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_SKIP
  } smb_state_e;

  // bits a host write may change
  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hA8;
      1:       return 8'h47;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h3F;
      5:       return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h47;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h00;
      default: return 8'h08;
    endcase
  endfunction

endpackage

// File: rtl/cfgsm_deglitch.sv
module cfgsm_deglitch #(
  parameter int STABLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CW'(STABLE_CYC - 1)) out_d = sync_q[1];
      else                              cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/cfgsm_proto.sv
module cfgsm_proto
  import cfgsm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         MAX_BYTES = 32,
  parameter int         IW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output smb_state_e    cur_st
);
  smb_state_e    st_q, st_d, nxt_q, nxt_d;
  logic          scl_q, sda_q;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          ackph_q, ackph_d, pull_q, pull_d, ok_q, ok_d;
  logic [IW-1:0] left_q, left_d, idx_q, idx_d;
  logic          rise, fall, start_ev, stop_ev;
  logic [7:0]    byte_in;

  assign rise     = scl_f & ~scl_q;
  assign fall     = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign byte_in  = {sh_q[6:0], sda_f};

  always_comb begin
    st_d    = st_q;
    nxt_d   = nxt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ackph_d = ackph_q;
    pull_d  = pull_q;
    ok_d    = ok_q;
    left_d  = left_q;
    idx_d   = idx_q;
    wr_en   = 1'b0;
    if (start_ev || stop_ev) begin
      st_d    = start_ev ? ST_ADDR : ST_IDLE;
      bit_d   = '0;
      ackph_d = 1'b0;
      pull_d  = 1'b0;
    end else if (st_q != ST_IDLE && st_q != ST_SKIP) begin
      if (rise && bit_q < 4'd8) begin
        sh_d  = byte_in;
        bit_d = bit_q + 4'd1;
        if (bit_q == 4'd7) begin
          case (st_q)
            ST_ADDR: begin
              ok_d  = (byte_in == {DEV_ADDR, 1'b0});
              nxt_d = ok_d ? ST_CMD : ST_SKIP;
            end
            ST_CMD: begin
              ok_d  = (byte_in == 8'h00);
              nxt_d = ok_d ? ST_CNT : ST_SKIP;
            end
            ST_CNT: begin
              ok_d   = (byte_in != 8'h00) && (byte_in <= 8'(MAX_BYTES));
              nxt_d  = ok_d ? ST_DATA : ST_SKIP;
              left_d = IW'(byte_in);
              idx_d  = '0;
            end
            default: begin
              ok_d  = (left_q != '0);
              nxt_d = ok_d ? ST_DATA : ST_SKIP;
              if (ok_d) begin
                wr_en  = 1'b1;
                left_d = left_q - IW'(1);
                idx_d  = idx_q + IW'(1);
              end
            end
          endcase
        end
      end else if (fall && bit_q == 4'd8) begin
        if (!ackph_q) begin
          ackph_d = 1'b1;
          pull_d  = ok_q;
        end else begin
          ackph_d = 1'b0;
          pull_d  = 1'b0;
          bit_d   = '0;
          st_d    = nxt_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bit_q   <= '0;
      sh_q    <= '0;
      ackph_q <= 1'b0;
      pull_q  <= 1'b0;
      ok_q    <= 1'b0;
      left_q  <= '0;
      idx_q   <= '0;
    end else begin
      st_q    <= st_d;
      nxt_q   <= nxt_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ackph_q <= ackph_d;
      pull_q  <= pull_d;
      ok_q    <= ok_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_idx   = idx_q;
  assign wr_data  = byte_in;
  assign cur_st   = st_q;
endmodule

// File: rtl/cfgsm_regbank.sv
module cfgsm_regbank
  import cfgsm_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  mode_strap,
  input  logic                  freq_strap,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic       cap_q;
  logic [1:0] strap_q, strap_d;

  assign strap_d = cap_q ? strap_q : {mode_strap, freq_strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      strap_q <= 2'b00;
    end else begin
      cap_q   <= 1'b1;
      strap_q <= strap_d;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(g);
    logic [7:0] q, d;

    always_comb begin
      d = q;
      if (wr_en && wr_idx == IW'(g)) d = (wr_data & MASK) | (q & ~MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rst_val(g);
      else        q <= d;
    end

    if (g == 0) begin : g_strap
      assign cfg_o[8*g +: 8] = {q[7:3], strap_q, q[0]};
    end else begin : g_plain
      assign cfg_o[8*g +: 8] = q;
    end
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfgsm_pkg::*;
#(
  parameter int         FILT_CYC  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         MAX_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  input  logic                  mode_strap,
  input  logic                  freq_strap,
  output logic [NUM_REGS*8-1:0] cfg_bytes
);
  localparam int IW = $clog2(MAX_BYTES + 1);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [1:0]    line_raw, line_f;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;
  smb_state_e    cur_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign line_raw = {sda_in, scl_in};

  for (genvar l = 0; l < 2; l++) begin : g_line
    cfgsm_deglitch #(.STABLE_CYC(FILT_CYC)) u_flt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (line_raw[l]),
      .line_o (line_f[l])
    );
  end

  cfgsm_proto #(.DEV_ADDR(DEV_ADDR), .MAX_BYTES(MAX_BYTES), .IW(IW)) u_proto (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (line_f[0]),
    .sda_f    (line_f[1]),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cur_st   (cur_st)
  );

  cfgsm_regbank #(.IW(IW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .mode_strap (mode_strap),
    .freq_strap (freq_strap),
    .cfg_o      (cfg_bytes)
  );
endmodule

// File: rtl/cfgsm_chk.sv
module cfgsm_chk
  import cfgsm_pkg::*;
#(
  parameter int IW        = 6,
  parameter int MAX_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          sda_pull,
  input smb_state_e    st,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [1:0]    strap_bits
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> $stable(strap_bits));

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);

  // R5
  wr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (scl_f && !$past(scl_f)));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_idx == $past(wr_idx) + IW'(1)));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IW'(MAX_BYTES)));
endmodule

bind cfg_smbus_slave cfgsm_chk #(.IW(IW), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .scl_f      (line_f[0]),
  .sda_pull   (sda_pull),
  .st         (cur_st),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .strap_bits (cfg_bytes[2:1])
);

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;
  localparam int H = 16;

  logic        clk = 1'b0;
  logic        rst_n, m_scl, m_sda, mode_s, freq_s, sda_pull, sda_bus;
  logic [55:0] cfg;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  exp_r [7];
  logic [7:0]  tx [40];
  bit          glitch_en = 1'b0;
  logic [7:0]  wm [7] = '{8'hA8, 8'h47, 8'h7F, 8'hFF, 8'h3F, 8'h7F, 8'h00};

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  cfg_smbus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .mode_strap(mode_s), .freq_strap(freq_s), .cfg_bytes(cfg)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [55:0] exp_vec();
    return {exp_r[6], exp_r[5], exp_r[4], exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
  endfunction

  function automatic void apply(input int idx, input logic [7:0] v);
    if (idx < 7) exp_r[idx] = (v & wm[idx]) | (exp_r[idx] & ~wm[idx]);
  endfunction

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int nbits, output bit acked, output bit drove);
    drove = 1'b0;
    acked = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      m_sda = b[i];
      wt(H/2);
      if (glitch_en && i == 4) begin m_scl = 1'b1; wt(1); m_scl = 1'b0; end
      wt(H/2);
      m_scl = 1'b1; wt(H/2);
      if (sda_pull) drove = 1'b1;
      wt(H/2);
      m_scl = 1'b0;
    end
    if (nbits == 8) begin
      m_sda = 1'b1; wt(H);
      m_scl = 1'b1; wt(H/2);
      acked = sda_pull;
      wt(H/2);
      m_scl = 1'b0; wt(H/2);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                      input int nb, input bit do_stop, input string req);
    bit ok, ack, drv;
    logic [7:0] b;
    ok = 1'b0;
    bus_start();
    for (int k = 0; k < nb + 3; k++) begin
      if (k == 0)      begin b = a; ok = (a == 8'hD2); end
      else if (k == 1) begin b = c; ok = ok && (c == 8'h00); end
      else if (k == 2) begin b = n; ok = ok && (n >= 8'd1) && (n <= 8'd32); end
      else             begin b = tx[k-3]; ok = ok && ((k - 3) < int'(n)); end
      send_byte(b, 8, ack, drv);
      if (k >= 3 && ok) apply(k - 3, b);
      check(req, 64'(ack), 64'(ok));
      check("R9", 64'(drv), 64'd0);
    end
    if (do_stop) bus_stop();
    wt(8);
    check(req, 64'(cfg), 64'(exp_vec()));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    bit ack, drv;
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_scl = 1'b1; m_sda = 1'b1; mode_s = 1'b1; freq_s = 1'b0; rst_n = 1'b0;
    exp_r = '{8'h0C, 8'h47, 8'h7F, 8'hC7, 8'h3F, 8'h00, 8'h08};
    wt(5);
    rst_n = 1'b1;
    wt(10);
    // R1 reset values, strap mirror
    for (int i = 0; i < 7; i++) check("R1", 64'(cfg[8*i +: 8]), 64'(exp_r[i]));
    mode_s = 1'b0; freq_s = 1'b1;
    wt(10);
    check("R1", 64'(cfg[7:0]), 64'h0C);

    // R5 / R7: all ones, then all zeros, over every register
    for (int i = 0; i < 7; i++) tx[i] = 8'hFF;
    xfer(8'hD2, 8'h00, 8'd7, 7, 1'b1, "R7");
    for (int i = 0; i < 7; i++) tx[i] = 8'h00;
    xfer(8'hD2, 8'h00, 8'd7, 7, 1'b1, "R5");
    // R2 wrong address, R3 wrong command, R4 bad counts
    tx[0] = 8'hA5;
    xfer(8'hD4, 8'h00, 8'd1, 1, 1'b1, "R2");
    xfer(8'hD2, 8'h01, 8'd1, 1, 1'b1, "R3");
    xfer(8'hD2, 8'h00, 8'd0, 1, 1'b1, "R4");
    xfer(8'hD2, 8'h00, 8'd33, 2, 1'b1, "R4");
    // R8 bytes past count
    tx[0] = 8'h88; tx[1] = 8'h01; tx[2] = 8'hFF; tx[3] = 8'hFF;
    xfer(8'hD2, 8'h00, 8'd2, 4, 1'b1, "R8");
    // R8 full count of 32, plus one extra
    for (int i = 0; i < 33; i++) tx[i] = 8'(8'h5A ^ i);
    xfer(8'hD2, 8'h00, 8'd32, 33, 1'b1, "R8");

    // R6 stop mid-byte: first data byte kept, second cut off
    bus_start();
    send_byte(8'hD2, 8, ack, drv);
    send_byte(8'h00, 8, ack, drv);
    send_byte(8'h04, 8, ack, drv);
    send_byte(8'h20, 8, ack, drv);
    apply(0, 8'h20);
    send_byte(8'h00, 4, ack, drv);
    bus_stop();
    wt(8);
    check("R6", 64'(cfg), 64'(exp_vec()));

    // R10 short SCL glitch inside low phases
    glitch_en = 1'b1;
    tx[0] = 8'h80; tx[1] = 8'h05;
    xfer(8'hD2, 8'h00, 8'd2, 2, 1'b1, "R10");
    glitch_en = 1'b0;

    // R11 repeated start restarts at register 0
    tx[0] = 8'h08; tx[1] = 8'h42;
    xfer(8'hD2, 8'h00, 8'd3, 2, 1'b0, "R11");
    tx[0] = 8'hA8;
    xfer(8'hD2, 8'h00, 8'd1, 1, 1'b1, "R11");

    // random transfers
    for (int r = 0; r < 12; r++) begin
      logic [7:0] a, c, n;
      int nb;
      a  = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
      c  = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
      n  = 8'($urandom % 36);
      nb = int'($urandom % 10);
      for (int i = 0; i < 10; i++) tx[i] = 8'($urandom);
      xfer(a, c, n, nb, 1'b1, "R5");
    end
    report();
  end
endmodule